// File: doc/BRIEF.md
# Compressed Instruction Realigner

This block sits between a fetch unit that delivers 32-bit words and a core that runs a mix of 16-bit compressed and 32-bit instructions. Instructions are packed on halfword boundaries, so one instruction may start in the upper half of a word and end in the lower half of the next. The block turns the word stream into a stream of whole instructions. Each instruction is offered on a valid/ready port together with its byte address and its error flags.

A 16-bit register holds the upper half of a word that has not yet been used. That register, together with bit 1 of the output address, decides where the next instruction comes from: the current fetch word, the held halfword, or both joined together. A redirect input loads a new even target address and empties the held halfword. After that the fetch side restarts at the word that contains the target. An error on a fetch word is passed to the core. A separate flag marks the case where only the second half of a joined 32-bit instruction was faulty. After an error has been handed over, the block stays quiet until the next redirect.

Top module: `insn_realign`

## Requirements
- R1: A halfword whose bits [1:0] equal 2'b11 starts a 32-bit instruction; any other value is a complete 16-bit instruction. A good 16-bit instruction is presented in `insn_data[15:0]` with `insn_data[31:16]` zero. A good 32-bit instruction has its first halfword in bits [15:0] and its second in bits [31:16].
- R2: `insn_addr` is the byte address of the presented instruction. After a good instruction is accepted, the address grows by 2 for a 16-bit instruction and by 4 for a 32-bit one.
- R3: The held halfword can be valid only while `insn_addr[1]` is 1. While `insn_addr[1]` is 0, the presented instruction comes from the current fetch word alone, so `insn_valid` equals `fetch_valid`.
- R4: At a word-aligned address, accepting the instruction consumes the fetch word. A 16-bit instruction leaves the word's upper half held in the register.
- R5: At an odd-halfword address with nothing held, an upper half that starts a 32-bit instruction is taken into the register with the word consumed (`fetch_ready`=1) and nothing presented (`insn_valid`=0). An upper half that is a 16-bit instruction is presented directly.
- R6: With a halfword held, a held 16-bit instruction is presented at once (`insn_valid`=1) without consuming a word (`fetch_ready`=0). A held first half of a 32-bit instruction is joined with the lower half of the fetch word, and the upper half of that word is kept in the register.
- R7: Once `insn_valid` is high and not accepted, it stays high in the next cycle unless a redirect came. While stalled, `insn_addr`, `insn_err` and `insn_data[15:0]` keep their values, and `insn_data[31:16]` also keeps its value for a 32-bit instruction.
- R8: A redirect must carry an even address. In the cycle after it, `insn_addr` equals that address and nothing is held. During the redirect cycle `fetch_ready` is 0 and no handshake takes effect.
- R9: `insn_err` is set when the word holding the first half of the instruction was faulty. For a joined instruction it is also set when the second word was faulty, and then `insn_err_upper` is 1. `insn_err_upper` is only ever 1 together with `insn_err` and `insn_data[1:0]`=2'b11.
- R10: After reset and after an erroneous instruction is accepted, `insn_valid` stays 0 and incoming words are discarded (`fetch_ready`=1) until a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Fetch word is present |
| fetch_ready | output | 1 | Fetch word is consumed this cycle |
| fetch_word | input | 32 | Fetch word, lower halfword at the lower address |
| fetch_err | input | 1 | Fetch word is faulty |
| redirect | input | 1 | Load a new instruction address |
| redirect_addr | input | ADDR_W | New instruction address, bit 0 clear |
| insn_valid | output | 1 | An instruction is presented |
| insn_ready | input | 1 | Core accepts the presented instruction |
| insn_data | output | 32 | Presented instruction |
| insn_addr | output | ADDR_W | Byte address of the presented instruction |
| insn_err | output | 1 | Instruction is faulty |
| insn_err_upper | output | 1 | Fault lies only in the second half of a 32-bit instruction |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a reset address of zero. Redirect targets are kept inside a 4 KiB window. Instruction content and word faults are fixed functions of the address, so any target can be revisited and checked against the same expected stream. This window holds enough even and odd-halfword targets, joined instructions across word boundaries, and occasional faulty words that every branch of the realignment is hit many times: redirect into the middle of a word, first-half capture, faults in either half, and quiet phases after faults.

// File: rtl/ria_pkg.sv
package ria_pkg;

    localparam int HW   = 16;
    localparam int WORD = 2 * HW;

    // Position of the realigner relative to the current fetch word
    typedef enum logic [1:0] {
        PH_ALIGNED   = 2'd0,  // address bit 1 clear, nothing held
        PH_MIS_EMPTY = 2'd1,  // address bit 1 set, nothing held
        PH_MIS_SKID  = 2'd2,  // address bit 1 set, halfword held
        PH_IDLE      = 2'd3   // no valid address since reset or error
    } phase_e;

    typedef struct packed {
        logic            valid;
        logic [WORD-1:0] data;
        logic            err;
        logic            err_upper;
    } insn_t;

    typedef struct packed {
        logic take_word;  // fetch word consumed
        logic fire;       // presented instruction accepted
        logic wide;       // accepted instruction is 32-bit
        logic load_skid;  // keep upper half of fetch word
        logic drop_skid;  // held halfword used up
        logic halt;       // erroneous instruction accepted
    } step_t;

    function automatic logic is_wide(input logic [HW-1:0] half);
        return half[1:0] == 2'b11;
    endfunction

    function automatic phase_e phase_of(input logic idle, input logic mis,
                                        input logic held);
        if (idle)      return PH_IDLE;
        else if (!mis) return PH_ALIGNED;
        else if (held) return PH_MIS_SKID;
        else           return PH_MIS_EMPTY;
    endfunction

endpackage

// File: rtl/ria_decide.sv
module ria_decide
    import ria_pkg::*;
(
    input  phase_e          phase,
    input  logic            word_valid,
    input  logic [WORD-1:0] word,
    input  logic            word_err,
    input  logic [HW-1:0]   held,
    input  logic            out_ready,
    input  logic            redirect,
    output insn_t           out,
    output step_t           st,
    output logic            fetch_ready
);

    logic [HW-1:0] lo_half;
    logic [HW-1:0] hi_half;
    logic          lo_wide;
    logic          hi_wide;
    logic          held_wide;

    assign lo_half   = word[HW-1:0];
    assign hi_half   = word[WORD-1:HW];
    assign lo_wide   = is_wide(lo_half);
    assign hi_wide   = is_wide(hi_half);
    assign held_wide = is_wide(held);

    always_comb begin
        out = '0;
        st  = '0;
        unique case (phase)
            PH_IDLE: begin
                st.take_word = 1'b1;
            end
            PH_ALIGNED: begin
                out.valid     = word_valid;
                out.data      = lo_wide ? word : {{HW{1'b0}}, lo_half};
                out.err       = word_err;
                st.fire       = word_valid & out_ready;
                st.take_word  = word_valid & out_ready;
                st.wide       = lo_wide;
                st.load_skid  = word_valid & out_ready & ~word_err & ~lo_wide;
                st.halt       = word_valid & out_ready & word_err;
            end
            PH_MIS_EMPTY: begin
                if (word_err || !hi_wide) begin
                    out.valid    = word_valid;
                    out.data     = word_err ? word : {{HW{1'b0}}, hi_half};
                    out.err      = word_err;
                    st.fire      = word_valid & out_ready;
                    st.take_word = word_valid & out_ready;
                    st.halt      = word_valid & out_ready & word_err;
                end else begin
                    st.take_word = word_valid;
                    st.load_skid = word_valid;
                end
            end
            PH_MIS_SKID: begin
                if (!held_wide) begin
                    out.valid    = 1'b1;
                    out.data     = {{HW{1'b0}}, held};
                    st.fire      = out_ready;
                    st.drop_skid = out_ready;
                end else begin
                    out.valid     = word_valid;
                    out.data      = {lo_half, held};
                    out.err       = word_err;
                    out.err_upper = word_err;
                    st.fire       = word_valid & out_ready;
                    st.take_word  = word_valid & out_ready;
                    st.wide       = 1'b1;
                    st.load_skid  = word_valid & out_ready & ~word_err;
                    st.halt       = word_valid & out_ready & word_err;
                end
            end
            default: begin
                st = '0;
            end
        endcase
        if (redirect) begin
            st = '0;
        end
    end

    assign fetch_ready = st.take_word;

endmodule

// File: rtl/ria_skid.sv
module ria_skid
    import ria_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [HW-1:0] upper_half,
    output logic [HW-1:0] held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held <= upper_half;
        end
    end

endmodule

// File: rtl/ria_track.sv
module ria_track
    import ria_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  step_t             st,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    output logic [ADDR_W-1:0] addr_q,
    output phase_e            phase
);

    localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(4);

    logic held_q;
    logic idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= START_ADDR;
            held_q <= 1'b0;
            idle_q <= 1'b1;
        end else if (redirect) begin
            addr_q <= redirect_addr;
            held_q <= 1'b0;
            idle_q <= 1'b0;
        end else if (st.halt) begin
            held_q <= 1'b0;
            idle_q <= 1'b1;
        end else begin
            if (st.fire) begin
                addr_q <= addr_q + (st.wide ? STEP_WIDE : STEP_NARROW);
            end
            if (st.load_skid) begin
                held_q <= 1'b1;
            end else if (st.drop_skid) begin
                held_q <= 1'b0;
            end
        end
    end

    assign phase = phase_of(idle_q, addr_q[1], held_q);

    AST_HELD_ONLY_MISALIGNED: assert property (@(posedge clk) disable iff (rst)
        held_q |-> addr_q[1]); // R3

    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (st.fire && !st.halt && !redirect) |=>
        (addr_q == $past(addr_q) + ($past(st.wide) ? STEP_WIDE : STEP_NARROW))); // R2

    AST_REDIRECT_LOADS: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (addr_q == $past(redirect_addr)) && !held_q); // R8

endmodule

// File: rtl/insn_realign.sv
module insn_realign
    import ria_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [31:0]       fetch_word,
    input  logic              fetch_err,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    output logic              insn_valid,
    input  logic              insn_ready,
    output logic [31:0]       insn_data,
    output logic [ADDR_W-1:0] insn_addr,
    output logic              insn_err,
    output logic              insn_err_upper
);

    phase_e        phase;
    step_t         st;
    insn_t         out;
    logic [HW-1:0] held;

    ria_decide u_decide (
        .phase       (phase),
        .word_valid  (fetch_valid),
        .word        (fetch_word),
        .word_err    (fetch_err),
        .held        (held),
        .out_ready   (insn_ready),
        .redirect    (redirect),
        .out         (out),
        .st          (st),
        .fetch_ready (fetch_ready)
    );

    ria_skid u_skid (
        .clk        (clk),
        .rst        (rst),
        .load       (st.load_skid),
        .upper_half (fetch_word[WORD-1:HW]),
        .held       (held)
    );

    ria_track #(
        .ADDR_W     (ADDR_W),
        .START_ADDR (START_ADDR)
    ) u_track (
        .clk           (clk),
        .rst           (rst),
        .st            (st),
        .redirect      (redirect),
        .redirect_addr (redirect_addr),
        .addr_q        (insn_addr),
        .phase         (phase)
    );

    assign insn_valid     = out.valid;
    assign insn_data      = out.data;
    assign insn_err       = out.err;
    assign insn_err_upper = out.err_upper;

    logic stalled;
    assign stalled = insn_valid && !insn_ready && !redirect;

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        stalled |=> insn_valid); // R7

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        stalled |=> $stable(insn_addr)); // R7

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        stalled |=> $stable(insn_err)); // R7

    AST_LOW_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
        stalled |=> $stable(insn_data[15:0])); // R7

    AST_HIGH_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stalled && insn_data[1:0] == 2'b11) |=> $stable(insn_data[31:16])); // R7

    AST_UPPER_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        insn_err_upper |-> (insn_err && insn_data[1:0] == 2'b11)); // R9

    AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !redirect_addr[0]); // R8

    AST_REDIRECT_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !fetch_ready); // R8

endmodule

// File: tb/tb_insn_realign.sv
module tb_insn_realign;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              fetch_valid;
    logic              fetch_ready;
    logic [31:0]       fetch_word;
    logic              fetch_err;
    logic              redirect;
    logic [ADDR_W-1:0] redirect_addr;
    logic              insn_valid;
    logic              insn_ready;
    logic [31:0]       insn_data;
    logic [ADDR_W-1:0] insn_addr;
    logic              insn_err;
    logic              insn_err_upper;

    always #10 clk = ~clk;  // 50 MHz

    insn_realign #(.ADDR_W(ADDR_W)) dut (
        .clk            (clk),
        .rst            (rst),
        .fetch_valid    (fetch_valid),
        .fetch_ready    (fetch_ready),
        .fetch_word     (fetch_word),
        .fetch_err      (fetch_err),
        .redirect       (redirect),
        .redirect_addr  (redirect_addr),
        .insn_valid     (insn_valid),
        .insn_ready     (insn_ready),
        .insn_data      (insn_data),
        .insn_addr      (insn_addr),
        .insn_err       (insn_err),
        .insn_err_upper (insn_err_upper)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Memory model: halfword content and word faults are functions of address
    function automatic logic [15:0] hw_at(input logic [31:0] a);
        logic [31:0] h;
        logic [15:0] r;
        h = (a ^ 32'h0000_5A5A) * 32'h9E37_79B1;
        h = h ^ (h >> 13);
        r = h[31:16];
        if (h[3]) r[1:0] = 2'b11;
        return r;
    endfunction

    function automatic logic err_at(input logic [31:0] a);
        logic [31:0] h;
        h = (a >> 2) * 32'h85EB_CA6B;
        h = h ^ (h >> 11);
        return h[31:26] == 6'd0;
    endfunction

    function automatic logic wide(input logic [15:0] h);
        return h[1:0] == 2'b11;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    logic [31:0] fptr;
    bit          fvalid;
    logic [31:0] exp_addr;
    bit          held_exp;
    bit          live;
    bit          stall_prev;
    logic [31:0] prev_data;
    logic [31:0] prev_addr;
    logic        prev_err;
    int          accepted;
    int          splits;
    int          joined_err;

    initial begin
        $urandom(32'd1234);
        rst = 1'b1;
        fetch_valid = 1'b0;
        fetch_word = '0;
        fetch_err = 1'b0;
        redirect = 1'b0;
        redirect_addr = '0;
        insn_ready = 1'b0;
        fptr = '0;
        fvalid = 1'b0;
        exp_addr = '0;
        held_exp = 1'b0;
        live = 1'b0;
        stall_prev = 1'b0;
        prev_data = '0;
        prev_addr = '0;
        prev_err = 1'b0;
        accepted = 0;
        splits = 0;
        joined_err = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(insn_valid == 1'b0, "R10 reset quiet", 32'(insn_valid), 32'd0);
        rst = 1'b0;
        #2;
        chk(insn_valid == 1'b0, "R10 idle after reset", 32'(insn_valid), 32'd0);
        chk(fetch_ready == 1'b1, "R10 discard after reset", 32'(fetch_ready), 32'd1);

        for (int cyc = 0; cyc < 40000; cyc++) begin
            bit          redir;
            logic [31:0] target;
            @(negedge clk);
            // directed targets first, then random ones
            if (cyc < 4) begin
                redir = (cyc % 2 == 0);
                target = (cyc == 0) ? 32'h0000_0100 : 32'h0000_0202;
            end else begin
                redir = live ? ($urandom % 40 == 0) : ($urandom % 3 == 0);
                target = {20'd0, 11'($urandom), 1'b0};
            end
            redirect = redir;
            redirect_addr = target;
            if (!fvalid) fvalid = ($urandom % 4 != 0);
            fetch_valid = fvalid;
            fetch_word = {hw_at(fptr + 32'd2), hw_at(fptr)};
            fetch_err = err_at(fptr);
            insn_ready = ($urandom % 4 != 0);
            #2;
            if (redir) begin
                chk(fetch_ready == 1'b0, "R8 no word taken on redirect", 32'(fetch_ready), 32'd0);
                fptr = target & ~32'd3;
                fvalid = 1'b0;
                exp_addr = target;
                held_exp = 1'b0;
                live = 1'b1;
                stall_prev = 1'b0;
                continue;
            end
            if (stall_prev) begin
                chk(insn_valid == 1'b1, "R7 valid held", 32'(insn_valid), 32'd1);
                chk(insn_addr == prev_addr, "R7 addr held", insn_addr, prev_addr);
                chk(insn_err == prev_err, "R7 err held", 32'(insn_err), 32'(prev_err));
                chk(insn_data[15:0] == prev_data[15:0], "R7 low half held",
                    32'(insn_data[15:0]), 32'(prev_data[15:0]));
                if (prev_data[1:0] == 2'b11)
                    chk(insn_data[31:16] == prev_data[31:16], "R7 high half held",
                        32'(insn_data[31:16]), 32'(prev_data[31:16]));
            end
            if (!live) begin
                chk(insn_valid == 1'b0, "R10 quiet until redirect", 32'(insn_valid), 32'd0);
                chk(fetch_ready == 1'b1, "R10 words discarded", 32'(fetch_ready), 32'd1);
                stall_prev = 1'b0;
            end else begin
                logic [15:0] lo;
                logic [15:0] hi;
                logic        e_err;
                logic        e_up;
                lo = hw_at(exp_addr);
                hi = hw_at(exp_addr + 32'd2);
                e_err = err_at(exp_addr);
                e_up = 1'b0;
                if (!e_err && wide(lo) && exp_addr[1]) begin
                    e_up = err_at(exp_addr + 32'd2);
                    e_err = e_up;
                end
                if (!exp_addr[1]) begin
                    chk(insn_valid == fetch_valid, "R3 aligned follows fetch",
                        32'(insn_valid), 32'(fetch_valid));
                end else if (held_exp && !wide(lo)) begin
                    chk(insn_valid == 1'b1, "R6 held short presented", 32'(insn_valid), 32'd1);
                    chk(fetch_ready == 1'b0, "R6 no word for held short", 32'(fetch_ready), 32'd0);
                end else if (!held_exp && fetch_valid && !fetch_err && wide(lo)) begin
                    chk(insn_valid == 1'b0, "R5 first half absorbed", 32'(insn_valid), 32'd0);
                    chk(fetch_ready == 1'b1, "R5 word consumed", 32'(fetch_ready), 32'd1);
                    held_exp = 1'b1;
                    splits++;
                end
                if (insn_valid) begin
                    chk(insn_addr == exp_addr, "R2 address", insn_addr, exp_addr);
                    chk(insn_err == e_err, "R9 error flag", 32'(insn_err), 32'(e_err));
                    chk(insn_err_upper == e_up, "R9 upper error flag",
                        32'(insn_err_upper), 32'(e_up));
                    if (insn_err_upper)
                        chk(insn_err && insn_data[1:0] == 2'b11, "R9 upper err qualified",
                            32'(insn_data[1:0]), 32'd3);
                    if (!e_err) begin
                        if (wide(lo))
                            chk(insn_data == {hi, lo},
                                exp_addr[1] ? "R6 joined 32-bit" : "R4 aligned 32-bit",
                                insn_data, {hi, lo});
                        else
                            chk(insn_data == {16'h0, lo},
                                exp_addr[1] ? "R1 short at odd half" : "R1 short at even half",
                                insn_data, {16'h0, lo});
                    end else if (e_up) begin
                        chk(insn_data[15:0] == lo, "R9 first half kept on upper error",
                            32'(insn_data[15:0]), 32'(lo));
                        joined_err++;
                    end
                    if (insn_ready) begin
                        accepted++;
                        if (e_err) begin
                            live = 1'b0;
                            held_exp = 1'b0;
                        end else begin
                            if (!exp_addr[1] && !wide(lo))
                                chk(fetch_ready == 1'b1, "R4 word consumed with short",
                                    32'(fetch_ready), 32'd1);
                            exp_addr = exp_addr + (wide(lo) ? 32'd4 : 32'd2);
                            held_exp = exp_addr[1];
                        end
                    end
                end
                stall_prev = insn_valid && !insn_ready;
                prev_data = insn_data;
                prev_addr = insn_addr;
                prev_err = insn_err;
            end
            if (fetch_valid && fetch_ready) begin
                fvalid = 1'b0;
                fptr = fptr + 32'd4;
            end
        end
        chk(accepted > 1000, "R2 progress", 32'(accepted), 32'd1000);
        chk(splits > 10, "R5 split captures seen", 32'(splits), 32'd10);
        chk(joined_err > 0, "R9 upper-half faults seen", 32'(joined_err), 32'd1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule